// File: doc/BRIEF.md
# Derandomizing Event Buffer with Serial Delay Line

This block delays a stream of asynchronous single-bit events by a fixed number of shift periods. The events land in a serial shift register that advances once per shift period. A shift period is `SHIFT_DIV` cycles of the fast sampling clock. The register can hold at most one event per period, so the block places a small buffer in front of it.

An input latch takes the first event of each period. Up to two overflow stores, chosen by the `ORDER` parameter, keep events that arrive while the latch is occupied. Stored events are fed into the line in later periods instead of being lost. Any event that finds every slot full is discarded, and a one-cycle drop strobe reports it.

The output is the delayed serial stream. Each bit of the line is presented for one whole shift period. A strobe marks the last cycle of every period, so a consumer can sample the stream there.

Top module: `evt_derand_delay`

## Requirements
- R1: The delay line advances only on the clock edge that ends a shift period. `shift_tick` is high in the last cycle of every `SHIFT_DIV`-cycle period. `dly_out` changes only on that edge. A bit entered into the line appears on `dly_out` after `DEPTH` shift edges.
- R2: `evt_async` passes through a two-flop synchronizer, and each of its rising edges counts as one event. An input that is first high at clock edge k counts as arriving at edge k+2. An arrival on the edge that ends a period belongs to that period.
- R3: The first event of a period occupies the input latch, which is always free at the start of a period when no store is occupied. That event enters the line at the end of the period and is never dropped.
- R4: With `ORDER` of 1 or more, the second event of a period goes into the first store. It enters the line in the following period.
- R5: Suppose the first store is full and the next period brings one new event. The stored event goes into the line, and the new event takes the store's place.
- R6: An event that arrives while the latch and every enabled store are full is discarded. `drop_o` is then high for exactly the one cycle after the edge on which that event arrived.
- R7: With `ORDER` of 2, the second store fills only when the first store is already full. At a period boundary the second store empties before the first.
- R8: With `ORDER` of 0 there are no stores, and every event after the first in a period is dropped.
- R9: While `rst_n` is low, `dly_out`, `drop_o` and `shift_tick` are low, and the latch, stores and line are cleared. The release of `rst_n` passes through two flops before it takes effect.
- R10: Once the block is idle and drained, the number of events received equals the number of ones seen on `dly_out` plus the number of drop strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| evt_async | input | 1 | Asynchronous event input; each rising edge is one event |
| shift_tick | output | 1 | High in the last cycle of each shift period |
| dly_out | output | 1 | Delayed serial event stream, one bit per shift period |
| drop_o | output | 1 | One-cycle strobe for each discarded event |

## Verification
An event counts two edges after the input is first sampled high. It enters the line on the next period-ending edge, and it reaches `dly_out` after `DEPTH` more shift edges. A drop shows on `drop_o` in the cycle right after the edge on which the event arrived. The bench runs a cycle-accurate reference of these rules for orders 0, 1 and 2 side by side. It updates that reference on each rising edge and compares both outputs of all three instances at every falling edge. It takes the period boundary from `shift_tick` as sampled on the preceding falling edge. Directed bursts are started right after a strobed period boundary, so every event lands in a known period. Their totals are counted once the line and the stores have drained.

// File: rtl/evt_dly_pkg.sv
package evt_dly_pkg;

  // occupancy of the input latch and the two overflow stores
  typedef struct packed {
    logic held;
    logic st1;
    logic st2;
  } occ_t;

  localparam int unsigned MAX_ORDER = 2;

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/shift_timer.sv
module shift_timer #(
  parameter int unsigned DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R1

endmodule

// File: rtl/derand_buf.sv
module derand_buf
  import evt_dly_pkg::*;
#(
  parameter int unsigned ORDER = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic tick_i,
  output logic shift_bit_o,
  output logic drop_o
);

  localparam bit USE_ST1 = (ORDER >= 1);
  localparam bit USE_ST2 = (ORDER >= MAX_ORDER);

  occ_t occ_q, occ_a, occ_d;
  logic drop_d;
  logic occ_en;

  // arrival first, then release at the period boundary
  always_comb begin
    occ_a  = occ_q;
    drop_d = 1'b0;
    if (evt_i) begin
      if (!occ_q.held)                 occ_a.held = 1'b1;
      else if (USE_ST1 && !occ_q.st1)  occ_a.st1  = 1'b1;
      else if (USE_ST2 && !occ_q.st2)  occ_a.st2  = 1'b1;
      else                             drop_d     = 1'b1;
    end
    shift_bit_o = occ_a.held;
    occ_d = occ_a;
    if (tick_i) begin
      occ_d.held = occ_a.st1 | occ_a.st2;
      if (occ_a.st2) occ_d.st2 = 1'b0;
      else           occ_d.st1 = 1'b0;
    end
  end

  assign occ_en = evt_i | tick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q  <= '0;
      drop_o <= 1'b0;
    end else begin
      if (occ_en) occ_q <= occ_d;
      drop_o <= drop_d;
    end
  end

  AST_ST2_NEEDS_ST1: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q.st2 |-> occ_q.st1); // R7
  AST_ST2_FIRST_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && occ_q.st1 && occ_q.st2 |=> occ_q.held && occ_q.st1 && !occ_q.st2); // R7
  AST_STORE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !evt_i && occ_q.st1 && !occ_q.st2 |=> occ_q.held && !occ_q.st1); // R4
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && occ_q.held && (!USE_ST1 || occ_q.st1) && (!USE_ST2 || occ_q.st2) |=> drop_o); // R6
  AST_FREE_LATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i && !occ_q.held |=> !drop_o); // R3

endmodule

// File: rtl/delay_line.sv
module delay_line #(
  parameter int unsigned DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en_i,
  input  logic din_i,
  output logic dout_o
);

  logic [DEPTH-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sr_q <= '0;
    else if (shift_en_i) sr_q <= {sr_q[DEPTH-2:0], din_i};
  end

  assign dout_o = sr_q[DEPTH-1];

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en_i |=> $stable(dout_o)); // R1

endmodule

// File: rtl/evt_derand_delay.sv
module evt_derand_delay #(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned SHIFT_DIV = 8,
  parameter int unsigned ORDER     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_async,
  output logic shift_tick,
  output logic dly_out,
  output logic drop_o
);

  logic [1:0] rst_pipe_q;
  logic       rst_int_n;
  logic       rise;
  logic       tick;
  logic       shift_bit;

  // reset asserts at once and releases two edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  evt_sync_edge #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .async_i(evt_async), .rise_o(rise)
  );

  shift_timer #(.DIV(SHIFT_DIV)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .tick_o(tick)
  );

  derand_buf #(.ORDER(ORDER)) u_buf (
    .clk(clk), .rst_n(rst_int_n), .evt_i(rise), .tick_i(tick),
    .shift_bit_o(shift_bit), .drop_o(drop_o)
  );

  delay_line #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst_n(rst_int_n), .shift_en_i(tick),
    .din_i(shift_bit), .dout_o(dly_out)
  );

  assign shift_tick = tick;

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    !rst_int_n |-> !dly_out && !drop_o && !shift_tick); // R9

endmodule

// File: tb/evt_derand_delay_tb_top.sv
module evt_derand_delay_tb_top;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned DIV   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic evt = 1'b0;
  logic [2:0] tick_w, dly_w, drp_w;

  always #5 clk = ~clk;

  evt_derand_delay #(.DEPTH(DEPTH), .SHIFT_DIV(DIV), .ORDER(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_async(evt),
    .shift_tick(tick_w[2]), .dly_out(dly_w[2]), .drop_o(drp_w[2]));
  evt_derand_delay #(.DEPTH(DEPTH), .SHIFT_DIV(DIV), .ORDER(1)) dut_o1 (
    .clk(clk), .rst_n(rst_n), .evt_async(evt),
    .shift_tick(tick_w[1]), .dly_out(dly_w[1]), .drop_o(drp_w[1]));
  evt_derand_delay #(.DEPTH(DEPTH), .SHIFT_DIV(DIV), .ORDER(0)) dut_o0 (
    .clk(clk), .rst_n(rst_n), .evt_async(evt),
    .shift_tick(tick_w[0]), .dly_out(dly_w[0]), .drop_o(drp_w[0]));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit run_cmp = 1'b0;

  // reference state
  logic m1 = 0, m2 = 0, m3 = 0;
  logic tick_s = 0;
  logic held [3];
  logic st1 [3];
  logic st2 [3];
  logic [DEPTH-1:0] msr [3];
  logic exp_drop [3];
  int outs [3];
  int drops [3];
  int sent = 0;

  initial begin
    for (int o = 0; o < 3; o++) begin
      held[o] = 0; st1[o] = 0; st2[o] = 0; msr[o] = '0; exp_drop[o] = 0;
      outs[o] = 0; drops[o] = 0;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference update on each rising edge
  always @(posedge clk) begin
    logic a;
    a  = m2 & ~m3;
    m3 = m2; m2 = m1; m1 = evt;
    for (int o = 0; o < 3; o++) begin
      logic dr;
      dr = 0;
      if (a) begin
        if (!held[o]) held[o] = 1;
        else if (o >= 1 && !st1[o]) st1[o] = 1;
        else if (o >= 2 && !st2[o]) st2[o] = 1;
        else dr = 1;
      end
      if (tick_s) begin
        msr[o]  = {msr[o][DEPTH-2:0], held[o]};
        held[o] = st1[o] | st2[o];
        if (st2[o]) st2[o] = 0; else st1[o] = 0;
      end
      exp_drop[o] = dr;
    end
  end

  // comparison on each falling edge
  always @(negedge clk) begin
    if (run_cmp) begin
      for (int o = 0; o < 3; o++) begin
        chk($sformatf("R1 R2 dly order%0d", o), int'(dly_w[o]), int'(msr[o][DEPTH-1]));
        chk($sformatf("R6 drop order%0d", o), int'(drp_w[o]), int'(exp_drop[o]));
        if (tick_w[2] && dly_w[o]) outs[o]++;
        if (drp_w[o]) drops[o]++;
      end
    end
    tick_s = tick_w[2];
  end

  task automatic align();
    while (!tick_w[2]) @(negedge clk);
  endtask

  task automatic burst(input int n);
    for (int k = 0; k < n; k++) begin
      evt = 1; sent++;
      @(negedge clk);
      evt = 0;
      @(negedge clk);
    end
  endtask

  task automatic scen(input int p1, input int p2, input string tag,
                      input int o0o, input int o0d, input int o1o, input int o1d,
                      input int o2o, input int o2d);
    for (int o = 0; o < 3; o++) begin outs[o] = 0; drops[o] = 0; end
    align();
    burst(p1);
    align();
    burst(p2);
    repeat ((DEPTH + 4) * DIV) @(negedge clk);
    chk({tag, " order0 outs"}, outs[0], o0o);
    chk({tag, " order0 drops"}, drops[0], o0d);
    chk({tag, " order1 outs"}, outs[1], o1o);
    chk({tag, " order1 drops"}, drops[1], o1d);
    chk({tag, " order2 outs"}, outs[2], o2o);
    chk({tag, " order2 drops"}, drops[2], o2d);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R9 quiet outputs while reset is held
    chk("R9 reset dly", int'(dly_w), 0);
    chk("R9 reset drop", int'(drp_w), 0);
    chk("R9 reset tick", int'(tick_w), 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    repeat (3 * DIV) @(negedge clk);

    scen(1, 0, "R3 single",      1, 0, 1, 0, 1, 0);
    scen(2, 0, "R4 R8 pair",     1, 1, 2, 0, 2, 0);
    scen(3, 0, "R7 triple",      1, 2, 2, 1, 3, 0);
    scen(4, 0, "R6 quad",        1, 3, 2, 2, 3, 1);
    scen(2, 1, "R5 refill",      2, 1, 3, 0, 3, 0);
    scen(4, 2, "R7 R6 sustain",  2, 4, 3, 3, 4, 2);

    // random traffic, then drain and count (R10)
    for (int o = 0; o < 3; o++) begin outs[o] = 0; drops[o] = 0; end
    sent = 0;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4000; c++) begin
      if (evt) evt = 0;
      else if (($urandom % 100) < 30) begin evt = 1; sent++; end
      @(negedge clk);
    end
    evt = 0;
    repeat ((DEPTH + 6) * DIV) @(negedge clk);
    for (int o = 0; o < 3; o++)
      chk($sformatf("R10 balance order%0d", o), outs[o] + drops[o], sent);

    finish_up();
  end

endmodule